// File: doc/BRIEF.md
# RTC Update-Cycle Interrupt Logic

This block reproduces the once-per-second update cycle of a real-time clock and the interrupt that marks its completion. A sub-second counter advances on a one-cycle microsecond tick and wraps once per second. A fixed number of ticks before each second boundary, the update-in-progress status bit goes high. On the boundary it drops again, the update-ended flag is latched and, when the host has enabled it, the interrupt summary flag is set and the interrupt line is driven.

The host reaches the block through an index/data port. An index write selects a register. Data read and data write strobes then move one byte, and each access takes one clock. Three registers take part: a status register holding the update-in-progress bit and the reference/rate selection, a control register holding the update inhibit and the update-ended interrupt enable, and a flag register that clears itself when read. A fourth index returns a fixed validity byte. The interrupt output is a level. Every new interrupt is preceded by one low cycle, so an edge-triggered receiver always sees a rising edge.

Top module: `rtc_upd_irq`

## Requirements
- R1: After reset, register A (index 0x0A) reads 0x26, which is reference select 010 in bits 6:4 and rate 0110 in bits 3:0. Register B (index 0x0B) and register C (index 0x0C) read 0x00, irq is low and the sub-second count is 0.
- R2: The sub-second count advances by one only in cycles where us_tick is high, and it wraps from TICKS_PER_SEC-1 to 0. Cycles without a tick leave it unchanged.
- R3: Register A bit 7 (update in progress) reads 1 exactly while the count lies in TICKS_PER_SEC-UIP_LEAD_US to TICKS_PER_SEC-1 and no inhibit is active. It reads 0 at every other count.
- R4: The tick that wraps the count ends the update. From the next cycle, A bit 7 reads 0 and register C bit 4 (update-ended flag) reads 1.
- R5: If register B bit 4 (update-ended interrupt enable) is 1 when an update ends, register C bit 7 (interrupt summary) is set and irq is driven high. irq is high only while C bit 7 is set.
- R6: A data read at index 0x0C returns the current flags, then clears register C to 0x00 and drives irq low.
- R7: While register B bit 7 (inhibit) is 1, A bit 7 stays 0 and no update ends. Setting the inhibit during the window clears A bit 7 at once. Clearing it mid-window does not reopen the window before the next second.
- R8: A write to register B that takes bit 4 from 0 to 1 while C bit 4 is already set raises an interrupt at once: C bit 7 is set and irq goes through the same low-then-high sequence.
- R9: Every raised interrupt drives irq low in the cycle after the raising event and high in the cycle after that, even if irq was already high.
- R10: Writes to index 0x0C and 0x0D are ignored, and index 0x0D always reads 0x80. A bit 7 cannot be written. A write to A stores only bits 6:0.
- R11: When a read of register C falls in the same cycle as an update end, the read returns the flags from before the update. The flags and interrupt produced by that update are kept, not cleared.
- R12: An index write selects the register for every later data access until the next index write. rdata is registered: it changes only in the cycle after a data read and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle microsecond tick that advances the sub-second count |
| idx_wr | input | 1 | Loads wdata into the register index |
| data_wr | input | 1 | Writes wdata to the selected register |
| data_rd | input | 1 | Reads the selected register into rdata |
| wdata | input | 8 | Index or data byte from the host |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request to the host |

## Verification
The sharpest collision is a host read of the flag register that lands in the same cycle as the tick that ends an update. If the clear wins over the new flags, an interrupt is lost. The bench provokes this by selecting the flag register and asserting the read strobe and the final tick in the same cycle. It then expects the old (empty) flags in rdata, one low cycle on irq followed by a high one, and a second read that returns both the update-ended flag and the summary flag. A second overlap, an enable write arriving while the update-ended flag is already pending, is judged by the same low-then-high irq sequence.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  // register indices (host software decodes these)
  localparam logic [7:0] IDX_STAT = 8'h0A;
  localparam logic [7:0] IDX_CTRL = 8'h0B;
  localparam logic [7:0] IDX_FLAG = 8'h0C;
  localparam logic [7:0] IDX_VALID = 8'h0D;

  // bit positions
  localparam int STAT_BUSY_BIT = 7;
  localparam int CTRL_HOLD_BIT = 7;
  localparam int CTRL_UEN_BIT  = 4;
  localparam int FLAG_SUM_BIT  = 7;
  localparam int FLAG_UEND_BIT = 4;

  localparam logic [6:0] STAT_RESET_LOW = 7'h26;
  localparam logic [7:0] VALID_BYTE     = 8'h80;

  // next value of a counter that wraps after period-1
  function automatic int unsigned wrap_inc(int unsigned cur, int unsigned period);
    return (cur == period - 1) ? 0 : cur + 1;
  endfunction

  // first count at which the busy window is open
  function automatic int unsigned window_first(int unsigned period, int unsigned lead);
    return period - lead;
  endfunction

  // assemble the flag byte
  function automatic logic [7:0] pack_flags(logic sum, logic uend);
    logic [7:0] v;
    v = 8'h00;
    v[FLAG_SUM_BIT]  = sum;
    v[FLAG_UEND_BIT] = uend;
    return v;
  endfunction

  // assemble the status byte
  function automatic logic [7:0] pack_stat(logic busy, logic [6:0] low);
    return {busy, low};
  endfunction

endpackage

// File: rtl/rtc_subsec_ctr.sv
module rtc_subsec_ctr
  import rtc_upd_pkg::*;
#(
  parameter int unsigned TICKS = 1000000,
  parameter int unsigned LEAD  = 244,
  parameter int unsigned CW    = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          us_tick,
  output logic [CW-1:0] count,
  output logic          win_open,
  output logic          boundary
);

  localparam int unsigned LAST_CNT = TICKS - 1;
  localparam int unsigned PRE_OPEN = window_first(TICKS, LEAD) - 1;

  assign boundary = us_tick && (count == CW'(LAST_CNT));
  assign win_open = us_tick && (count == CW'(PRE_OPEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (us_tick) begin
      count <= CW'(wrap_inc(32'(count), TICKS));
    end
  end

endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic win_open,
  input  logic boundary,
  input  logic hold,
  output logic busy,
  output logic upd_end
);

  // an update ends only if its busy window actually ran
  assign upd_end = boundary && busy && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (hold || boundary) begin
      busy <= 1'b0;
    end else if (win_open) begin
      busy <= 1'b1;
    end
  end

endmodule

// File: rtl/rtc_flag_irq.sv
module rtc_flag_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_end,
  input  logic uen,
  input  logic uen_rise,
  input  logic rd_flags,
  output logic uend_flag,
  output logic sum_flag,
  output logic raise,
  output logic irq
);

  logic rearm;
  logic late_en;

  assign late_en = uen_rise && (uend_flag || upd_end);
  assign raise   = (upd_end && uen) || late_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uend_flag <= 1'b0;
      sum_flag  <= 1'b0;
    end else begin
      // new events win over a clear in the same cycle
      uend_flag <= upd_end || (uend_flag && !rd_flags);
      sum_flag  <= raise || (sum_flag && !rd_flags);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      rearm <= 1'b0;
    end else if (raise) begin
      irq   <= 1'b0;
      rearm <= 1'b1;
    end else if (rd_flags) begin
      irq   <= 1'b0;
      rearm <= 1'b0;
    end else if (rearm) begin
      irq   <= 1'b1;
      rearm <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
  import rtc_upd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] wdata,
  input  logic       busy,
  input  logic       uend_flag,
  input  logic       sum_flag,
  output logic [7:0] rdata,
  output logic       hold,
  output logic       uen,
  output logic       uen_rise,
  output logic       rd_flags
);

  logic [7:0] idx_q;
  logic [6:0] stat_low;
  logic [7:0] ctrl_q;
  logic       wr_stat;
  logic       wr_ctrl;
  logic [7:0] rd_mux;

  assign wr_stat  = data_wr && (idx_q == IDX_STAT);
  assign wr_ctrl  = data_wr && (idx_q == IDX_CTRL);
  assign rd_flags = data_rd && (idx_q == IDX_FLAG);
  assign hold     = ctrl_q[CTRL_HOLD_BIT];
  assign uen      = ctrl_q[CTRL_UEN_BIT];
  assign uen_rise = wr_ctrl && wdata[CTRL_UEN_BIT] && !ctrl_q[CTRL_UEN_BIT];

  always_comb begin
    case (idx_q)
      IDX_STAT:  rd_mux = pack_stat(busy, stat_low);
      IDX_CTRL:  rd_mux = ctrl_q;
      IDX_FLAG:  rd_mux = pack_flags(sum_flag, uend_flag);
      IDX_VALID: rd_mux = VALID_BYTE;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= 8'h00;
      stat_low <= STAT_RESET_LOW;
      ctrl_q   <= 8'h00;
      rdata    <= 8'h00;
    end else begin
      if (idx_wr) idx_q <= wdata;
      if (wr_stat) stat_low <= wdata[6:0];
      if (wr_ctrl) ctrl_q <= wdata;
      if (data_rd) rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/rtc_upd_irq.sv
module rtc_upd_irq #(
  parameter int unsigned TICKS_PER_SEC = 1000000,
  parameter int unsigned UIP_LEAD_US   = 244
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       idx_wr,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);

  localparam int unsigned CW = $clog2(TICKS_PER_SEC);

  logic [CW-1:0] count;
  logic          win_open;
  logic          boundary;
  logic          busy;
  logic          upd_end;
  logic          hold;
  logic          uen;
  logic          uen_rise;
  logic          rd_flags;
  logic          uend_flag;
  logic          sum_flag;
  logic          raise;

  rtc_subsec_ctr #(
    .TICKS(TICKS_PER_SEC),
    .LEAD (UIP_LEAD_US),
    .CW   (CW)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .us_tick (us_tick),
    .count   (count),
    .win_open(win_open),
    .boundary(boundary)
  );

  rtc_upd_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_open(win_open),
    .boundary(boundary),
    .hold    (hold),
    .busy    (busy),
    .upd_end (upd_end)
  );

  rtc_flag_irq u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_end  (upd_end),
    .uen      (uen),
    .uen_rise (uen_rise),
    .rd_flags (rd_flags),
    .uend_flag(uend_flag),
    .sum_flag (sum_flag),
    .raise    (raise),
    .irq      (irq)
  );

  rtc_reg_port u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .wdata    (wdata),
    .busy     (busy),
    .uend_flag(uend_flag),
    .sum_flag (sum_flag),
    .rdata    (rdata),
    .hold     (hold),
    .uen      (uen),
    .uen_rise (uen_rise),
    .rd_flags (rd_flags)
  );

endmodule

// File: rtl/rtc_upd_irq_chk.sv
module rtc_upd_irq_chk #(
  parameter int unsigned TICKS = 1000000,
  parameter int unsigned LEAD  = 244,
  parameter int unsigned CW    = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          busy,
  input logic          upd_end,
  input logic          hold,
  input logic          raise,
  input logic          rd_flags,
  input logic          uend_flag,
  input logic          sum_flag,
  input logic          irq
);

  localparam int unsigned FIRST = TICKS - LEAD;

  AST_BUSY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (count >= CW'(FIRST))); // R3

  AST_BUSY_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |=> !busy); // R4

  AST_UEND_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |=> uend_flag); // R4

  AST_HOLD_BLOCKS_END: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !upd_end); // R7

  AST_HOLD_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !busy); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !raise && !upd_end) |=> (!uend_flag && !sum_flag && !irq)); // R6

  AST_IRQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> !irq); // R9

  AST_IRQ_NEEDS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sum_flag); // R5

endmodule

bind rtc_upd_irq rtc_upd_irq_chk #(
  .TICKS(TICKS_PER_SEC),
  .LEAD (UIP_LEAD_US),
  .CW   (CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count    (count),
  .busy     (busy),
  .upd_end  (upd_end),
  .hold     (hold),
  .raise    (raise),
  .rd_flags (rd_flags),
  .uend_flag(uend_flag),
  .sum_flag (sum_flag),
  .irq      (irq)
);

// File: tb/rtc_upd_irq_tb.sv
module rtc_upd_irq_tb;

  localparam int unsigned T = 1000;
  localparam int unsigned L = 244;
  localparam logic [7:0] XA = 8'h0A, XB = 8'h0B, XC = 8'h0C, XD = 8'h0D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       us_tick = 1'b0;
  logic       idx_wr = 1'b0;
  logic       data_wr = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  rtc_upd_irq #(.TICKS_PER_SEC(T), .UIP_LEAD_US(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .idx_wr(idx_wr),
    .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_idx(input logic [7:0] i);
    idx_wr = 1'b1; wdata = i;
    @(negedge clk);
    idx_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, output logic [7:0] val);
    set_idx(i);
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    val = rdata;
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] val);
    set_idx(i);
    data_wr = 1'b1; wdata = val;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    us_tick = 1'b1;
    repeat (n) @(negedge clk);
    us_tick = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(XA, v); chk("R1 A", v, 8'h26);
    rd(XB, v); chk("R1 B", v, 8'h00);
    rd(XC, v); chk("R1 C", v, 8'h00);
  endtask

  task automatic t_window;
    ticks(T - L - 1);
    rd(XA, v); chk("R3 before window", v, 8'h26);
    idle(50);
    ticks(1);
    rd(XA, v); chk("R2/R3 window opens after held count", v, 8'hA6);
    ticks(L - 1);
    rd(XA, v); chk("R3 last count", v, 8'hA6);
    ticks(1);
    rd(XA, v); chk("R4 busy cleared", v, 8'h26);
    chk("R4 no irq without enable", {7'd0, irq}, 8'h00);
    rd(XC, v); chk("R4 flag set", v, 8'h10);
    rd(XC, v); chk("R6 flags cleared", v, 8'h00);
  endtask

  task automatic t_enable;
    wr(XB, 8'h10);
    ticks(T);
    chk("R9 gap cycle", {7'd0, irq}, 8'h00);
    idle(1);
    chk("R5 irq high", {7'd0, irq}, 8'h01);
    ticks(T);
    chk("R9 re-edge while high", {7'd0, irq}, 8'h00);
    idle(1);
    chk("R9 high again", {7'd0, irq}, 8'h01);
    rd(XC, v); chk("R5 flags", v, 8'h90);
    chk("R6 irq dropped", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_inhibit;
    wr(XB, 8'h90);
    ticks(T - 1);
    rd(XA, v); chk("R7 no busy while held", v, 8'h26);
    ticks(1);
    rd(XC, v); chk("R7 no update while held", v, 8'h00);
    chk("R7 no irq", {7'd0, irq}, 8'h00);
    wr(XB, 8'h10);
    ticks(T - 2);
    rd(XA, v); chk("R3 busy open", v, 8'hA6);
    wr(XB, 8'h90);
    rd(XA, v); chk("R7 hold clears busy", v, 8'h26);
    wr(XB, 8'h10);
    rd(XA, v); chk("R7 no reopen mid window", v, 8'h26);
    ticks(2);
    rd(XC, v); chk("R7 aborted update", v, 8'h00);
    chk("R7 irq low", {7'd0, irq}, 8'h00);
    wr(XB, 8'h00);
  endtask

  task automatic t_late;
    ticks(T);
    chk("R8 no irq yet", {7'd0, irq}, 8'h00);
    wr(XB, 8'h10);
    chk("R8 gap cycle", {7'd0, irq}, 8'h00);
    idle(1);
    chk("R8 irq raised", {7'd0, irq}, 8'h01);
    rd(XC, v); chk("R8 flags", v, 8'h90);
    wr(XB, 8'h00);
  endtask

  task automatic t_readonly;
    ticks(T);
    wr(XC, 8'h00);
    wr(XD, 8'h00);
    wr(XA, 8'hFF);
    rd(XA, v); chk("R10 A bit7 not writable", v, 8'h7F);
    wr(XA, 8'h26);
    rd(XD, v); chk("R10 D fixed", v, 8'h80);
    rd(XC, v); chk("R10 C write ignored", v, 8'h10);
  endtask

  task automatic t_collide;
    wr(XB, 8'h10);
    ticks(T - 1);
    set_idx(XC);
    data_rd = 1'b1; us_tick = 1'b1;
    @(negedge clk);
    data_rd = 1'b0; us_tick = 1'b0;
    chk("R11 read returns old flags", rdata, 8'h00);
    chk("R11 gap cycle", {7'd0, irq}, 8'h00);
    idle(1);
    chk("R11 irq kept", {7'd0, irq}, 8'h01);
    rd(XC, v); chk("R11 new flags kept", v, 8'h90);
  endtask

  task automatic t_port;
    rd(XA, v);
    idle(3);
    chk("R12 rdata holds", rdata, 8'h26);
    set_idx(XB);
    chk("R12 index write leaves rdata", rdata, 8'h26);
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    chk("R12 read B", rdata, 8'h10);
    set_idx(XD);
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    chk("R12 read D", rdata, 8'h80);
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    chk("R12 index persists", rdata, 8'h80);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_window;
    t_enable;
    t_inhibit;
    t_late;
    t_readonly;
    t_collide;
    t_port;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule